// File: doc/BRIEF.md
# I/O Access Sequencer

This block sits between the load/store stage of a pipelined processor and the paths to its data cache and external bus. Each data access it accepts is classified as either ordinary memory or I/O. An access counts as I/O when its address lies in the top 16 MB of the 32-bit space, or when either of two active-low signals from board logic is low in the classification cycle. One signal inhibits caching. The other reports that an external I/O decoder has claimed the cycle.

Memory accesses get a registered cacheable flag and are released after one stall cycle. I/O accesses are never marked cacheable. They wait until the write buffer is empty, then go to the bus unit through a request/grant/done handshake. The pipeline stays stalled until done returns, so I/O reads and writes reach the bus one at a time and in program order.

Top module: `ioSequencer`

## Requirements
- R1: During and right after a synchronous active-high reset, `stall`, `busReq` and `cacheable` are low.
- R2: An access whose address bits [31:24] are all ones (0xFF000000 to 0xFFFFFFFF) is I/O: `cacheable` stays low and the access goes to the bus. 0xFEFFFFFF is not in the window.
- R3: `inhibitN` low in the classification cycle makes the access I/O.
- R4: `ioDecN` low in the classification cycle makes the access I/O.
- R5: `inhibitN` and `ioDecN` are sampled only at the edge one cycle after acceptance. Their values in the acceptance cycle or later have no effect, and the classification holds until the next acceptance.
- R6: A memory access (none of R2 to R4) raises `stall` for exactly the cycle after acceptance. From the following cycle `cacheable` is 1 and `stall` is 0, and `busReq` never rises.
- R7: An I/O access does not raise `busReq` until `wbEmpty` has been seen high at a clock edge. `busReq` rises in the cycle after that edge.
- R8: `busReq` stays high until a cycle with `busGrant`, then drops. `stall` stays high until the edge that sees `busDone`, and is low in the next cycle.
- R9: While `busReq` is high, `busAddr` and `busWrite` show the address and direction captured at acceptance.
- R10: A request is accepted only while `stall` is low. `reqValid` while stalled is ignored and does not change `busAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Load/store stage presents an access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Access address |
| inhibitN | input | 1 | Active-low cache inhibit from board logic |
| ioDecN | input | 1 | Active-low external I/O decode claim |
| wbEmpty | input | 1 | Write buffer holds no posted writes |
| busGrant | input | 1 | Bus unit takes the I/O request |
| busDone | input | 1 | Bus unit finished the I/O cycle |
| cacheable | output | 1 | Registered: latched access may use the data cache |
| stall | output | 1 | Holds the pipeline |
| busReq | output | 1 | I/O request to the bus unit |
| busWrite | output | 1 | Direction of the latched access |
| busAddr | output | 32 | Address of the latched access |

## Verification
Some rules are checked by assertions on every cycle. A cacheable flag never coexists with a latched address in the I/O window or with a live bus request. A bus request only rises after the write buffer was seen empty, and it is held until granted and dropped right after. The latched address does not move while stalled. Other behaviour needs the bench's scenarios: the two handshake inputs matter only in the sampling cycle, the exact cycle count of the memory path, the drain and grant latencies, and the window edges at 0xFEFFFFFF and 0xFF000000.

// File: rtl/ioSeqPkg.sv
package ioSeqPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_DRAIN,
    ST_REQ,
    ST_BUSY
  } seqState_t;

  typedef struct packed {
    logic capture;   // take a new access from the pipeline
    logic classify;  // sample handshake inputs, latch class
  } seqStrobe_t;
endpackage

// File: rtl/ioSeqDatapath.sv
module ioSeqDatapath
  import ioSeqPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IO_TOP_BITS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              inhibitN,
  input  logic              ioDecN,
  output logic              ioNow,
  output logic [ADDR_W-1:0] addrQ,
  output logic              writeQ,
  output logic              cacheableQ
);
  localparam int WIN_LSB = ADDR_W - IO_TOP_BITS;

  logic inWindow;

  assign inWindow = &addrQ[ADDR_W-1:WIN_LSB];
  assign ioNow    = inWindow | ~inhibitN | ~ioDecN;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ      <= '0;
      writeQ     <= 1'b0;
      cacheableQ <= 1'b0;
    end else begin
      if (strobe.capture) begin
        addrQ      <= reqAddr;
        writeQ     <= reqWrite;
        cacheableQ <= 1'b0;
      end
      if (strobe.classify) begin
        cacheableQ <= ~ioNow;
      end
    end
  end
endmodule

// File: rtl/ioSeqControl.sv
module ioSeqControl
  import ioSeqPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic       ioNow,
  input  logic       wbEmpty,
  input  logic       busGrant,
  input  logic       busDone,
  output seqStrobe_t strobe,
  output logic       stall,
  output logic       busReq
);
  seqState_t state, stateNext;

  always_comb begin
    stateNext      = state;
    strobe.capture  = 1'b0;
    strobe.classify = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          stateNext      = ST_SAMPLE;
        end
      end
      ST_SAMPLE: begin
        strobe.classify = 1'b1;
        if (!ioNow)       stateNext = ST_IDLE;
        else if (wbEmpty) stateNext = ST_REQ;
        else              stateNext = ST_DRAIN;
      end
      ST_DRAIN: if (wbEmpty)  stateNext = ST_REQ;
      ST_REQ:   if (busGrant) stateNext = ST_BUSY;
      ST_BUSY:  if (busDone)  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign stall  = (state != ST_IDLE);
  assign busReq = (state == ST_REQ);
endmodule

// File: rtl/ioSequencer.sv
module ioSequencer
  import ioSeqPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IO_TOP_BITS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              inhibitN,
  input  logic              ioDecN,
  input  logic              wbEmpty,
  input  logic              busGrant,
  input  logic              busDone,
  output logic              cacheable,
  output logic              stall,
  output logic              busReq,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr
);
  seqStrobe_t strobe;
  logic       ioNow;

  ioSeqControl ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .ioNow    (ioNow),
    .wbEmpty  (wbEmpty),
    .busGrant (busGrant),
    .busDone  (busDone),
    .strobe   (strobe),
    .stall    (stall),
    .busReq   (busReq)
  );

  ioSeqDatapath #(
    .ADDR_W      (ADDR_W),
    .IO_TOP_BITS (IO_TOP_BITS)
  ) dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .reqWrite   (reqWrite),
    .inhibitN   (inhibitN),
    .ioDecN     (ioDecN),
    .ioNow      (ioNow),
    .addrQ      (busAddr),
    .writeQ     (busWrite),
    .cacheableQ (cacheable)
  );
endmodule

// File: rtl/ioSeqChecker.sv
module ioSeqChecker #(
  parameter int ADDR_W      = 32,
  parameter int IO_TOP_BITS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wbEmpty,
  input logic              busGrant,
  input logic              cacheable,
  input logic              stall,
  input logic              busReq,
  input logic [ADDR_W-1:0] busAddr
);
  localparam int WIN_LSB = ADDR_W - IO_TOP_BITS;

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!stall && !busReq && !cacheable));

  a_r2_window_never_cached: assert property (@(posedge clk) disable iff (rst)
    cacheable |-> !(&busAddr[ADDR_W-1:WIN_LSB]));

  a_r6_io_not_cached: assert property (@(posedge clk) disable iff (rst)
    busReq |-> (!cacheable && stall));

  a_r7_drain_first: assert property (@(posedge clk) disable iff (rst)
    $rose(busReq) |-> $past(wbEmpty));

  a_r8_req_holds: assert property (@(posedge clk) disable iff (rst)
    (busReq && !busGrant) |=> busReq);

  a_r8_single_grant: assert property (@(posedge clk) disable iff (rst)
    (busReq && busGrant) |=> (!busReq && stall));

  a_r9_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (stall && $past(stall)) |-> $stable(busAddr));
endmodule

bind ioSequencer ioSeqChecker #(
  .ADDR_W      (ADDR_W),
  .IO_TOP_BITS (IO_TOP_BITS)
) chk (
  .clk       (clk),
  .rst       (rst),
  .wbEmpty   (wbEmpty),
  .busGrant  (busGrant),
  .cacheable (cacheable),
  .stall     (stall),
  .busReq    (busReq),
  .busAddr   (busAddr)
);

// File: tb/ioSequencer_test.sv
module ioSequencer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        inhibitN = 1'b1;
  logic        ioDecN = 1'b1;
  logic        wbEmpty = 1'b0;
  logic        busGrant = 1'b0;
  logic        busDone = 1'b0;
  logic        cacheable, stall, busReq, busWrite;
  logic [31:0] busAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  ioSequencer uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .inhibitN(inhibitN), .ioDecN(ioDecN),
    .wbEmpty(wbEmpty), .busGrant(busGrant), .busDone(busDone),
    .cacheable(cacheable), .stall(stall), .busReq(busReq),
    .busWrite(busWrite), .busAddr(busAddr)
  );

  function automatic bit expectIo(logic [31:0] a, logic inh, logic dec);
    return (a[31:24] == 8'hFF) || !inh || !dec;
  endfunction

  task automatic check(bit ok, string req, string what,
                       logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // One access from acceptance to completion; called at a negedge with stall low.
  task automatic access(logic [31:0] a, logic wr, logic inh, logic dec,
                        logic noiseInh, logic noiseDec,
                        int wbDelay, int grantDelay, int doneDelay);
    bit io;
    io = expectIo(a, inh, dec);
    reqValid = 1'b1; reqAddr = a; reqWrite = wr;
    inhibitN = noiseInh; ioDecN = noiseDec;  // R5: ignored in acceptance cycle
    step();
    check(stall == 1'b1, "R6", "stall in sample cycle", stall, 1);
    check(cacheable == 1'b0, "R6", "cacheable before class", cacheable, 0);
    reqValid = 1'b0; reqAddr = $urandom; reqWrite = $urandom;
    inhibitN = inh; ioDecN = dec; wbEmpty = (wbDelay == 0);
    step();
    inhibitN = $urandom; ioDecN = $urandom;  // R5: ignored after sampling
    check(cacheable == !io, "R2 R3 R4", "class", cacheable, !io);
    if (!io) begin
      check(stall == 1'b0, "R6", "stall after memory", stall, 0);
      check(busReq == 1'b0, "R6", "no busReq for memory", busReq, 0);
      check(busAddr == a, "R10", "latched addr", busAddr, a);
      return;
    end
    for (int k = 0; k < wbDelay; k++) begin
      check(busReq == 1'b0, "R7", "busReq before drain", busReq, 0);
      if (k == wbDelay - 1) wbEmpty = 1'b1;
      step();
    end
    wbEmpty = $urandom;
    check(busReq == 1'b1, "R7", "busReq after drain", busReq, 1);
    check(busAddr == a, "R9", "busAddr", busAddr, a);
    check(busWrite == wr, "R9", "busWrite", busWrite, wr);
    for (int g = 0; g < grantDelay; g++) begin
      step();
      check(busReq == 1'b1, "R8", "busReq held", busReq, 1);
    end
    busGrant = 1'b1;
    step();
    busGrant = 1'b0;
    check(busReq == 1'b0, "R8", "busReq after grant", busReq, 0);
    check(stall == 1'b1, "R8", "stall until done", stall, 1);
    for (int d = 0; d < doneDelay; d++) begin
      reqValid = (d == 0);  // R10: request while stalled
      reqAddr = ~a;
      step();
      check(stall == 1'b1, "R8", "stall waiting done", stall, 1);
    end
    reqValid = 1'b0;
    busDone = 1'b1;
    step();
    busDone = 1'b0;
    check(stall == 1'b0, "R8", "stall after done", stall, 0);
    check(busAddr == a, "R10", "addr kept after stalled request", busAddr, a);
    check(cacheable == 1'b0, "R5", "class held", cacheable, 0);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0417));
    @(negedge clk); @(negedge clk);
    check(stall == 1'b0 && busReq == 1'b0 && cacheable == 1'b0,
          "R1", "outputs in reset", {stall, busReq, cacheable}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(stall == 1'b0 && busReq == 1'b0 && cacheable == 1'b0,
          "R1", "outputs after reset", {stall, busReq, cacheable}, 0);

    // Directed: window edges (R2)
    access(32'hFEFF_FFFF, 0, 1, 1, 1, 1, 0, 0, 0);
    access(32'hFF00_0000, 0, 1, 1, 1, 1, 0, 1, 1);
    access(32'hFFFF_FFFF, 1, 1, 1, 1, 1, 2, 0, 2);
    // R3 and R4 alone
    access(32'h0000_1000, 1, 0, 1, 1, 1, 1, 2, 1);
    access(32'h1234_5678, 0, 1, 0, 1, 1, 3, 1, 0);
    // R5: handshake low only in acceptance cycle -> memory
    access(32'h0040_0000, 0, 1, 1, 0, 0, 0, 0, 0);
    // R7: long drain
    access(32'hFF80_0010, 1, 1, 1, 1, 1, 5, 3, 3);

    for (int n = 0; n < 60; n++) begin
      logic [31:0] a;
      a = $urandom;
      if ($urandom_range(9) < 3) a[31:24] = 8'hFF;
      access(a, 1'($urandom), $urandom_range(3) != 0, $urandom_range(3) != 0,
             1'($urandom), 1'($urandom), $urandom_range(3),
             $urandom_range(3), $urandom_range(3));
      // R10: idle gap
      step();
      check(stall == 1'b0, "R10", "idle without request", stall, 0);
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule